// File: doc/BRIEF.md
# Receive VLAN Tag Detector

This block watches the byte stream of a received Ethernet frame and reports whether the frame carries an 802.1Q tag whose tag control field equals a value programmed by the host. The stream arrives one byte per cycle on the receive clock. It is qualified by a valid strobe and marked by start-of-frame and end-of-frame flags. Byte position 1 is the first destination-address byte. The host writes the 16-bit tag value on its own clock. The value reaches the receive clock through a multi-stage synchroniser, so the host must leave at least four receive-clock cycles between consecutive writes.

At the end of every frame the block presents two values together: a match flag, and the maximum legal frame length that a downstream length checker applies to that frame. An untagged frame is limited to 1518 bytes. A matching tagged frame is limited to 1522 bytes. Both values hold until the next frame starts.

Top module: `vlan_rx_detect`

## Requirements
- R1: After receive reset, `vlan_hit` is 0 and `max_len` is 1518.
- R2: A frame of at least 16 bytes whose bytes 13 and 14 are 0x81 and 0x00, and whose bytes 15 and 16 equal tag bits [15:8] and [7:0], drives `vlan_hit` to 1 one cycle after its end-of-frame byte is accepted.
- R3: If byte 13 or byte 14 differs from the 0x8100 type value, `vlan_hit` is 0 at end of frame, even when bytes 15 and 16 equal the tag.
- R4: If byte 15 or byte 16 differs from the programmed tag, `vlan_hit` is 0 at end of frame.
- R5: `max_len` changes in the same cycle as `vlan_hit`. It is 1522 for a matching frame and 1518 otherwise.
- R6: One cycle after an accepted start-of-frame byte that is not also end of frame, `vlan_hit` is 0 and `max_len` is 1518. At all other times both outputs keep their value.
- R7: A frame shorter than 16 bytes never sets `vlan_hit`, whatever its bytes are.
- R8: A byte is counted only when `rx_valid` is 1. When `rx_valid` is 0, `rx_data`, `rx_sof` and `rx_eof` are ignored.
- R9: A tag written on `host_clk` is used for frames that start eight or more receive cycles after the write.
- R10: Bytes after position 16 do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_clk | input | 1 | Host clock |
| host_rst_n | input | 1 | Host-domain reset, active low |
| host_tag_we | input | 1 | Tag write strobe |
| host_tag_wdata | input | 16 | Tag value to write |
| rx_clk | input | 1 | Receive clock |
| rx_rst_n | input | 1 | Receive-domain reset, active low |
| rx_valid | input | 1 | Byte valid |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_data | input | 8 | Received byte |
| vlan_hit | output | 1 | Frame carried the programmed tag |
| max_len | output | 11 | Maximum legal length for the frame |

## Verification
The bench uses the default of two synchroniser stages, which sets the tag latency checked under R9. Random frames range from 1 to 40 bytes. This covers frames that end before byte 16, frames that end exactly on byte 16, and frames with long tails past the tag. Random valid gaps carry garbage on the data and flag inputs, which shows that the position counter advances only on accepted bytes.

// File: rtl/vlan_det_pkg.sv
package vlan_det_pkg;
    localparam int TAG_W          = 16;
    localparam int LEN_W          = 11;
    localparam int BASE_FRAME_LEN = 1518;
    localparam int VLAN_EXTRA     = 4;
    localparam logic [TAG_W-1:0] TPID_VALUE = 16'h8100;
    localparam int TYPE_POS       = 13;
    localparam int LAST_TAG_POS   = TYPE_POS + 3;
    localparam int POS_W          = $clog2(LAST_TAG_POS + 2);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             ok;
        logic             hit;
        logic [LEN_W-1:0] max_len;
    } parse_state_t;
endpackage

// File: rtl/vlan_tag_host_reg.sv
module vlan_tag_host_reg
    import vlan_det_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [TAG_W-1:0] wdata,
    output logic [TAG_W-1:0] tag
);
    logic [TAG_W-1:0] tag_d, tag_q;

    always_comb begin
        tag_d = tag_q;
        if (we) tag_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tag_q <= '0;
        else        tag_q <= tag_d;
    end

    assign tag = tag_q;
endmodule

// File: rtl/vlan_tag_sync.sv
module vlan_tag_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb stage_d[s] = async_in;
            end else begin : g_next
                always_comb stage_d[s] = stage_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_d[s];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/vlan_frame_parser.sv
module vlan_frame_parser
    import vlan_det_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] tag,
    input  logic             valid,
    input  logic             sof,
    input  logic             eof,
    input  logic [7:0]       data,
    output logic             hit,
    output logic [LEN_W-1:0] max_len
);
    localparam logic [POS_W-1:0] POS_T0  = POS_W'(TYPE_POS);
    localparam logic [POS_W-1:0] POS_T1  = POS_W'(TYPE_POS + 1);
    localparam logic [POS_W-1:0] POS_V0  = POS_W'(TYPE_POS + 2);
    localparam logic [POS_W-1:0] POS_V1  = POS_W'(LAST_TAG_POS);
    localparam logic [POS_W-1:0] POS_SAT = POS_W'(LAST_TAG_POS + 1);
    localparam logic [LEN_W-1:0] LEN_PLAIN  = LEN_W'(BASE_FRAME_LEN);
    localparam logic [LEN_W-1:0] LEN_TAGGED = LEN_W'(BASE_FRAME_LEN + VLAN_EXTRA);

    parse_state_t st_d, st_q;
    logic [POS_W-1:0] cur_pos;
    logic             ok_run;

    always_comb begin
        st_d = st_q;
        if (sof)                  cur_pos = POS_W'(1);
        else if (st_q.pos == POS_SAT) cur_pos = POS_SAT;
        else                      cur_pos = st_q.pos + POS_W'(1);

        ok_run = sof ? 1'b1 : st_q.ok;
        case (cur_pos)
            POS_T0:  ok_run = ok_run & (data == TPID_VALUE[15:8]);
            POS_T1:  ok_run = ok_run & (data == TPID_VALUE[7:0]);
            POS_V0:  ok_run = ok_run & (data == tag[15:8]);
            POS_V1:  ok_run = ok_run & (data == tag[7:0]);
            default: ok_run = ok_run;
        endcase

        if (valid) begin
            st_d.pos = cur_pos;
            st_d.ok  = ok_run;
            if (eof) begin
                st_d.hit     = ok_run && (cur_pos >= POS_V1);
                st_d.max_len = (ok_run && (cur_pos >= POS_V1)) ? LEN_TAGGED : LEN_PLAIN;
            end else if (sof) begin
                st_d.hit     = 1'b0;
                st_d.max_len = LEN_PLAIN;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pos     <= '0;
            st_q.ok      <= 1'b0;
            st_q.hit     <= 1'b0;
            st_q.max_len <= LEN_PLAIN;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit     = st_q.hit;
    assign max_len = st_q.max_len;

    // R6: outputs move only on an accepted start or end byte
    assert_hold_between_frames_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid && (sof || eof)) |=> ($stable(hit) && $stable(max_len)));

    // R6: an accepted start byte clears the status
    assert_clear_on_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && sof && !eof) |=> (!hit && max_len == LEN_PLAIN));

    // R2: a match can only appear right after an accepted end byte
    assert_hit_after_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit) |-> $past(valid && eof));

    // R7: a frame ending before byte 16 never matches
    assert_short_no_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && eof && (sof || st_q.pos < POS_V0)) |=> !hit);

    // R8: position never runs past its saturation value
    assert_pos_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pos <= POS_SAT);
endmodule

// File: rtl/vlan_rx_detect.sv
module vlan_rx_detect
    import vlan_det_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             host_clk,
    input  logic             host_rst_n,
    input  logic             host_tag_we,
    input  logic [15:0]      host_tag_wdata,
    input  logic             rx_clk,
    input  logic             rx_rst_n,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  logic [7:0]       rx_data,
    output logic             vlan_hit,
    output logic [10:0]      max_len
);
    logic [TAG_W-1:0] host_tag;
    logic [TAG_W-1:0] rx_tag;

    vlan_tag_host_reg i_host_reg (
        .clk   (host_clk),
        .rst_n (host_rst_n),
        .we    (host_tag_we),
        .wdata (host_tag_wdata),
        .tag   (host_tag)
    );

    vlan_tag_sync #(.WIDTH(TAG_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk      (rx_clk),
        .rst_n    (rx_rst_n),
        .async_in (host_tag),
        .sync_out (rx_tag)
    );

    vlan_frame_parser i_parser (
        .clk     (rx_clk),
        .rst_n   (rx_rst_n),
        .tag     (rx_tag),
        .valid   (rx_valid),
        .sof     (rx_sof),
        .eof     (rx_eof),
        .data    (rx_data),
        .hit     (vlan_hit),
        .max_len (max_len)
    );

    // R5: the limit always agrees with the match flag
    assert_len_tracks_hit_R5: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
        vlan_hit ? (max_len == 11'd1522) : (max_len == 11'd1518));
endmodule

// File: tb/test_vlan_rx_detect.sv
module test_vlan_rx_detect;
    logic        host_clk = 0, host_rst_n = 0, host_tag_we = 0;
    logic [15:0] host_tag_wdata = '0;
    logic        rx_clk = 0, rx_rst_n = 0, rx_valid = 0, rx_sof = 0, rx_eof = 0;
    logic [7:0]  rx_data = '0;
    logic        vlan_hit;
    logic [10:0] max_len;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [15:0] cur_tag = '0;
    logic [7:0]  fb [64];

    always #2 rx_clk = ~rx_clk;
    always #3.5 host_clk = ~host_clk;

    vlan_rx_detect i_vlan_rx_detect (.*);

    function automatic bit exp_hit(int n, logic [15:0] t);
        return (n >= 16) && fb[12] == 8'h81 && fb[13] == 8'h00 &&
               fb[14] == t[15:8] && fb[15] == t[7:0];
    endfunction

    task automatic check(string req, bit eh);
        logic [10:0] el;
        el = eh ? 11'd1522 : 11'd1518;
        checks++;
        if (vlan_hit !== eh || max_len !== el) begin
            fails++;
            $display("FAIL %s: hit=%0b len=%0d expected hit=%0b len=%0d", req, vlan_hit, max_len, eh, el);
        end
    endtask

    task automatic write_tag(logic [15:0] v);
        @(negedge host_clk);
        host_tag_we = 1; host_tag_wdata = v;
        @(negedge host_clk);
        host_tag_we = 0;
        cur_tag = v;
        repeat (8) @(negedge rx_clk);
    endtask

    task automatic fill(int n, bit good_type, bit good_tag);
        for (int i = 0; i < 64; i++) fb[i] = 8'($urandom);
        if (good_type) begin fb[12] = 8'h81; fb[13] = 8'h00; end
        if (good_tag) begin fb[14] = cur_tag[15:8]; fb[15] = cur_tag[7:0]; end
        if (!good_tag && fb[14] == cur_tag[15:8] && fb[15] == cur_tag[7:0]) fb[15] = ~fb[15];
    endtask

    // starts and ends at an rx negedge
    task automatic send(int n, int gap_max, string req);
        bit eh;
        eh = exp_hit(n, cur_tag);
        for (int i = 0; i < n; i++) begin
            repeat ($urandom_range(0, gap_max)) begin
                rx_valid = 0; rx_data = 8'($urandom);
                rx_sof = 1'($urandom); rx_eof = 1'($urandom); // R8: ignored
                @(negedge rx_clk);
            end
            rx_valid = 1; rx_data = fb[i]; rx_sof = (i == 0); rx_eof = (i == n - 1);
            @(negedge rx_clk);
            rx_valid = 0; rx_sof = 0; rx_eof = 0;
            if (i == 0 && n > 1) check("R6 clear at start", 1'b0);
        end
        check(req, eh);
        repeat (3) begin
            rx_data = 8'($urandom); rx_sof = 1'($urandom); rx_eof = 1'($urandom);
            @(negedge rx_clk);
        end
        rx_sof = 0; rx_eof = 0;
        check("R6 hold after end", eh);
    endtask

    initial begin
        repeat (150000) @(posedge rx_clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge rx_clk);
        check("R1 reset state", 1'b0);
        host_rst_n = 1; rx_rst_n = 1;
        @(negedge rx_clk);
        check("R1 after reset release", 1'b0);

        write_tag(16'h0123);
        fill(20, 1, 1); send(20, 0, "R2 tagged match");
        fill(20, 1, 1); fb[12] = 8'h88; send(20, 0, "R3 bad type high");
        fill(20, 1, 1); fb[13] = 8'h01; send(20, 0, "R3 bad type low");
        fill(20, 1, 1); fb[14] = 8'hFF; send(20, 0, "R4 bad tag high");
        fill(20, 1, 1); fb[15] = 8'h22; send(20, 0, "R4 bad tag low");
        fill(16, 1, 1); send(16, 0, "R5 exactly 16 bytes tagged");
        fill(15, 1, 1); send(15, 0, "R7 15-byte frame");
        fill(1, 1, 1);  send(1, 0, "R7 single byte frame");
        fill(40, 1, 1); fb[16] = 8'h81; fb[17] = 8'h00; send(40, 0, "R10 tail ignored");
        fill(24, 1, 1); send(24, 4, "R8 gapped tagged frame");
        write_tag(16'hBEEF);
        fill(20, 1, 1); send(20, 0, "R9 new tag matches");
        fb[14] = 8'h01; fb[15] = 8'h23; send(20, 0, "R9 old tag rejected");

        for (int k = 0; k < 300; k++) begin
            int n;
            if (k % 60 == 59) write_tag(16'($urandom));
            n = $urandom_range(1, 40);
            fill(n, $urandom_range(0, 9) < 6, $urandom_range(0, 9) < 7);
            send(n, $urandom_range(0, 3), "R2 random frame");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule